// File: doc/BRIEF.md
# Micro-op condition test evaluator

This block decides whether a micro-operation's predicate holds. A 16-bit condition selector and the current flags word arrive on its inputs. A single cycle of combinational logic returns a pass/fail answer and an error indication. There are no registers in the block. A pipeline stage places it between the flags register and the commit or skip decision of a predicated micro-op.

The selector space has two halves. Selectors 0 to 15 are positive tests, and selectors 16 to 31 return the complement of the positive test at selector minus 16. Four positive selectors are reserved for string-operation predicates, and the block does not support them. These four selectors, their four complements, and any selector above 31 raise the error output in place of a real answer.

Top module: `cond_eval`

## Requirements
- R1: Selectors 0 to 15 are positive tests. Selector 16+k (k = 0 to 15) returns the logical inverse of positive test k. Bit 4 of the selector chooses inversion and bits 3:0 choose the test.
- R2: Selector 0 always passes (`taken_o`=1). Selector 16 always fails (`taken_o`=0).
- R3: Single-flag tests read these flag bits: selector 1 reads emulation-carry (bit 12), selector 2 reads emulation-zero (bit 13), selector 8 reads overflow (bit 11), selector 9 reads carry (bit 0), selector 10 reads zero (bit 6), selector 12 reads sign (bit 7) and selector 13 reads parity (bit 2).
- R4: Selector 3 passes unless emulation-zero is clear and zero is set.
- R5: Selector 11 is carry OR zero. Selector 14 is sign XOR overflow. Selector 15 is (sign XOR overflow) OR zero.
- R6: Selectors 4 to 7 and 20 to 23 are unsupported string predicates. For these, `fault_o`=1 and `taken_o` is forced to 1.
- R7: Any selector above 31 gives `fault_o`=1 and `taken_o`=1.
- R8: Every other selector in 0 to 31 gives `fault_o`=0.
- R9: Flag bits other than the seven named in R3 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 16 | Condition selector |
| flags_i | input | 16 | Current flags word |
| taken_o | output | 1 | Condition satisfied (1 when faulting) |
| fault_o | output | 1 | Unsupported or out-of-range selector |

## Verification
All 32 in-range selectors are applied against all 128 combinations of the seven meaningful flags. This sweep tells each single-flag test apart from every other, and it separates the three compound tests from their single-flag parts. Each complement selector is predicted as the inverse of its positive partner, so a wrong inversion or an off-by-one in the half split shows up at once. The unused flag bits are driven with a pattern that varies while the meaningful flags stay fixed, which exposes any leak from those bits. Out-of-range selectors are taken from the band edge at 32, from odd bit positions, and from the all-ones value.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int CODE_W  = 16,
  parameter int FLAG_W  = 16,
  parameter int CF_POS  = 0,
  parameter int PF_POS  = 2,
  parameter int ZF_POS  = 6,
  parameter int SF_POS  = 7,
  parameter int OF_POS  = 11,
  parameter int ECF_POS = 12,
  parameter int EZF_POS = 13
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              taken_o,
  output logic              fault_o
);
  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] T_ALWAYS  = 4'd0;
  localparam logic [SEL_W-1:0] T_ECARRY  = 4'd1;
  localparam logic [SEL_W-1:0] T_EZERO   = 4'd2;
  localparam logic [SEL_W-1:0] T_EZ_OR_NZ= 4'd3;
  localparam logic [SEL_W-1:0] T_OVF     = 4'd8;
  localparam logic [SEL_W-1:0] T_CARRY   = 4'd9;
  localparam logic [SEL_W-1:0] T_ZERO    = 4'd10;
  localparam logic [SEL_W-1:0] T_BELOWEQ = 4'd11;
  localparam logic [SEL_W-1:0] T_SIGN    = 4'd12;
  localparam logic [SEL_W-1:0] T_PARITY  = 4'd13;
  localparam logic [SEL_W-1:0] T_LESS    = 4'd14;
  localparam logic [SEL_W-1:0] T_LESSEQ  = 4'd15;

  logic [SEL_W-1:0] sel;
  logic             inv, high_bits, string_sel, positive;
  logic             cf, pf, zf, sf, of, ecf, ezf;

  assign sel        = code_i[SEL_W-1:0];
  assign inv        = code_i[SEL_W];
  assign high_bits  = |code_i[CODE_W-1:SEL_W+1];
  assign string_sel = (sel[3:2] == 2'b01);

  assign cf  = flags_i[CF_POS];
  assign pf  = flags_i[PF_POS];
  assign zf  = flags_i[ZF_POS];
  assign sf  = flags_i[SF_POS];
  assign of  = flags_i[OF_POS];
  assign ecf = flags_i[ECF_POS];
  assign ezf = flags_i[EZF_POS];

  always_comb begin
    case (sel)
      T_ALWAYS:   positive = 1'b1;
      T_ECARRY:   positive = ecf;
      T_EZERO:    positive = ezf;
      T_EZ_OR_NZ: positive = ezf | ~zf;
      T_OVF:      positive = of;
      T_CARRY:    positive = cf;
      T_ZERO:     positive = zf;
      T_BELOWEQ:  positive = cf | zf;
      T_SIGN:     positive = sf;
      T_PARITY:   positive = pf;
      T_LESS:     positive = sf ^ of;
      T_LESSEQ:   positive = (sf ^ of) | zf;
      default:    positive = 1'b0;
    endcase
  end

  assign fault_o = high_bits | string_sel;
  assign taken_o = fault_o | (positive ^ inv);
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int CODE_W = 16,
  parameter int FLAG_W = 16
) (
  input logic [CODE_W-1:0] code_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              taken_o,
  input logic              fault_o
);
  logic in_range, strsel;
  assign in_range = (code_i < CODE_W'(32));
  assign strsel   = in_range && (code_i[3:0] >= 4'd4) && (code_i[3:0] <= 4'd7);

  always_comb begin
    p_fault_taken_r6: assert (!fault_o || taken_o)
      else $error("fault without taken");
    p_string_fault_r6: assert (!strsel || fault_o)
      else $error("string selector not faulting");
    p_range_fault_r7: assert (in_range || fault_o)
      else $error("out-of-range selector not faulting");
    p_clean_r8: assert (!(in_range && !strsel) || !fault_o)
      else $error("valid selector faulting");
    p_always_r2: assert (code_i != CODE_W'(0) || taken_o)
      else $error("selector 0 not taken");
    p_never_r2: assert (code_i != CODE_W'(16) || !taken_o)
      else $error("selector 16 taken");
    p_zero_test_r3: assert (code_i != CODE_W'(10) || taken_o == flags_i[6])
      else $error("zero test mismatch");
  end
endmodule

bind cond_eval cond_eval_chk #(.CODE_W(CODE_W), .FLAG_W(FLAG_W)) u_chk (
  .code_i(code_i), .flags_i(flags_i), .taken_o(taken_o), .fault_o(fault_o));

// File: tb/cond_eval_test.sv
module cond_eval_test;
  logic        clk = 1'b0;
  logic [15:0] code_i = '0;
  logic [15:0] flags_i = '0;
  logic        taken_o, fault_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  typedef struct { logic taken; logic fault; logic [15:0] code; logic [15:0] flags; string req; } exp_t;
  exp_t sb[$];

  localparam logic [15:0] USED = 16'h38C5;

  cond_eval uut (.code_i(code_i), .flags_i(flags_i), .taken_o(taken_o), .fault_o(fault_o));

  always #10 clk = ~clk;

  function automatic logic pos_test(input int k, input logic [15:0] f);
    logic c, p, z, s, o, ec, ez;
    c = f[0]; p = f[2]; z = f[6]; s = f[7]; o = f[11]; ec = f[12]; ez = f[13];
    case (k)
      0: return 1'b1;            // R2
      1: return ec;              // R3
      2: return ez;              // R3
      3: return !(!ez && z);     // R4
      8: return o;               // R3
      9: return c;               // R3
      10: return z;              // R3
      11: return c | z;          // R5
      12: return s;              // R3
      13: return p;              // R3
      14: return s ^ o;          // R5
      15: return (s ^ o) | z;    // R5
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int c);
    if (c > 31) return "R7";
    if ((c % 16) >= 4 && (c % 16) <= 7) return "R6";
    if (c == 0 || c == 16) return "R2";
    if ((c % 16) == 3) return "R4";
    if ((c % 16) == 11 || (c % 16) >= 14) return "R5";
    if (c >= 16) return "R1";
    return "R3";
  endfunction

  task automatic drive(input logic [15:0] c, input logic [15:0] f, input string rq);
    exp_t e;
    int ci;
    @(posedge clk);
    code_i = c; flags_i = f;
    ci = int'(c);
    e.code = c; e.flags = f;
    e.req = (rq != "") ? rq : req_of(ci);
    if (ci > 31 || ((ci % 16) >= 4 && (ci % 16) <= 7)) begin
      e.fault = 1'b1; e.taken = 1'b1;            // R6 R7
    end else if (ci >= 16) begin
      e.fault = 1'b0; e.taken = ~pos_test(ci - 16, f); // R1 R8
    end else begin
      e.fault = 1'b0; e.taken = pos_test(ci, f);       // R8
    end
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (taken_o !== e.taken || fault_o !== e.fault) begin
          errors++;
          $display("FAIL %s code=%0d flags=%h got taken=%b fault=%b expected taken=%b fault=%b",
                   e.req, e.code, e.flags, taken_o, fault_o, e.taken, e.fault);
        end
      end
    end
  end

  function automatic logic [15:0] spread(input logic [6:0] m);
    return {2'b00, m[6], m[5], m[4], 3'b000, m[3], m[2], 3'b000, m[1], 1'b0, m[0]};
  endfunction

  initial begin : stim
    drive(16'd0, 16'h0000, "R2");
    for (int c = 0; c < 32; c++)
      for (int m = 0; m < 128; m++)
        drive(16'(c), spread(7'(m)), "");
    for (int c = 0; c < 32; c++)
      for (int n = 0; n < 4; n++)
        drive(16'(c), (spread(7'(c * 5)) & USED) | ((16'hA5F3 << n) & ~USED), "R9");
    drive(16'd32, 16'h0000, "R7");
    drive(16'd33, 16'hFFFF, "R7");
    drive(16'd64, 16'h0040, "R7");
    drive(16'h0100, 16'h2000, "R7");
    drive(16'h8000, 16'h0000, "R7");
    drive(16'hFFFF, 16'h0000, "R7");
    drive(16'd20, 16'h0000, "R6");
    drive(16'd23, 16'hFFFF, "R6");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule